// File: doc/BRIEF.md
# Single-Slot Math Result Capture Buffer

This block sits between a shared, pipelined math engine (a rotator, divider or similar) and one processing core. Each command the core sends to the engine eventually comes back as one result made of two words, X and Y. The buffer keeps exactly one such pair. The engine is never held back. If a result comes back while the previous pair is still waiting for the core, the new result is thrown away and a sticky flag records the loss.

The core fetches the two words with separate read requests. A read against an empty slot stalls the requester while at least one command is still in flight. The read is released in the cycle after the engine's result is captured. If the slot is empty and no command is outstanding, the read finishes at once with an error indication, so the core can never wait forever. A small counter of commands in flight makes this decision possible. The slot is normally freed once both halves have been taken. A build option frees it on the Y read alone.

Top module: `mathres_slot`

## Requirements
- R1: An engine result (valid high) arriving while the slot is empty is captured, and the slot reads as holding a result from the next cycle on.
- R2: A read-X request while the slot holds a result completes in the same cycle without stall and presents the held X word on the read data output. When read-X and read-Y are requested together, X is served and read-Y stalls.
- R3: With the default build, the slot is freed once both X and Y of the held result have been read, in either order and repeated reads allowed. With RELEASE_ON_Y set, a Y read alone frees it.
- R4: A read request against an empty slot while one or more commands are in flight raises that request's stall output, and the read data output is zero.
- R5: A read-Y request alone while the slot holds a result completes without stall and presents the held Y word.
- R6: A stalled read is released in the cycle after the engine delivers a result, and it returns that result's word.
- R7: A result arriving while the slot is occupied and not being freed in that cycle is discarded, the held pair is unchanged, and the lost flag is set from the next cycle.
- R8: The lost flag stays set until the clear input is pulsed. It is low in the cycle after the clear, unless another result is dropped in the clear cycle, in which case it stays set.
- R9: A read against an empty slot with no command in flight does not stall, and it raises the error output in that cycle.
- R10: A result arriving in the same cycle as the read that frees the slot is accepted, and the lost flag is not set.
- R11: The in-flight count rises by one on each command-issue pulse and falls by one on each engine result, including dropped results. It saturates at zero and at its maximum.
- R12: After reset the slot is empty, the lost flag is clear and no command is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_issue_i | input | 1 | Core sent one command to the engine |
| eng_valid_i | input | 1 | Engine result present this cycle |
| eng_x_i | input | W | Engine result, X word |
| eng_y_i | input | W | Engine result, Y word |
| rd_x_req_i | input | 1 | Core requests the X word |
| rd_y_req_i | input | 1 | Core requests the Y word |
| rd_x_stall_o | output | 1 | Read-X must be held and retried |
| rd_y_stall_o | output | 1 | Read-Y must be held and retried |
| rd_err_o | output | 1 | Served read found nothing pending |
| rd_data_o | output | W | Word returned by the served read |
| lost_o | output | 1 | Sticky: a result was discarded |
| lost_clr_i | input | 1 | Clears the lost flag |

## Verification
Two functions can fall in the same cycle: the capture of an engine result and the core read that frees the slot. The bench forces this case directly by holding a half-read slot and pulsing the read-Y request together with engine valid. It then checks that the new X word is returned and that the lost flag stays low. A random phase hits the same case, along with capture against a plain read and drop against a lost-flag clear, many more times. Each cycle is judged against a behavioural model of slot, flags and in-flight count.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_X    = 2'd1,
    RD_Y    = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/mrs_pending.sv
module mrs_pending #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case ({inc_i, dec_i})
      2'b10: if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + CNT_ONE;
        cnt_en = 1'b1;
      end
      2'b01: if (cnt_q != '0) begin
        cnt_d  = cnt_q - CNT_ONE;
        cnt_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign nz_o = (cnt_q != '0);
endmodule

// File: rtl/mrs_reader.sv
module mrs_reader
  import mrs_pkg::*;
(
  input  logic    rd_x_req_i,
  input  logic    rd_y_req_i,
  input  logic    full_i,
  input  logic    pend_nz_i,
  output rd_sel_e sel_o,
  output logic    x_stall_o,
  output logic    y_stall_o,
  output logic    err_o
);
  always_comb begin
    sel_o     = RD_NONE;
    x_stall_o = 1'b0;
    y_stall_o = 1'b0;
    err_o     = 1'b0;
    if (rd_x_req_i) begin
      y_stall_o = rd_y_req_i;
      if (full_i)         sel_o     = RD_X;
      else if (pend_nz_i) x_stall_o = 1'b1;
      else                err_o     = 1'b1;
    end else if (rd_y_req_i) begin
      if (full_i)         sel_o     = RD_Y;
      else if (pend_nz_i) y_stall_o = 1'b1;
      else                err_o     = 1'b1;
    end
  end
endmodule

// File: rtl/mrs_slot.sv
module mrs_slot
  import mrs_pkg::*;
#(
  parameter int W            = 32,
  parameter bit RELEASE_ON_Y = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eng_valid_i,
  input  logic [W-1:0] eng_x_i,
  input  logic [W-1:0] eng_y_i,
  input  rd_sel_e      sel_i,
  input  logic         lost_clr_i,
  output logic         full_o,
  output logic         free_o,
  output logic         lost_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic         full_q, full_d;
  logic         x_tk_q, x_tk_d;
  logic         y_tk_q, y_tk_d;
  logic         lost_q, lost_d;
  logic [W-1:0] x_q, y_q;
  logic         free_w, cap_w, drop_w, flag_en;

  generate
    if (RELEASE_ON_Y) begin : g_rel_y
      assign free_w = (sel_i == RD_Y);
    end else begin : g_rel_both
      assign free_w = full_q & ((sel_i == RD_X) | x_tk_q)
                             & ((sel_i == RD_Y) | y_tk_q);
    end
  endgenerate

  assign cap_w  = eng_valid_i & (~full_q | free_w);
  assign drop_w = eng_valid_i & full_q & ~free_w;

  always_comb begin
    full_d = full_q;
    x_tk_d = x_tk_q;
    y_tk_d = y_tk_q;
    if (cap_w) begin
      full_d = 1'b1;
      x_tk_d = 1'b0;
      y_tk_d = 1'b0;
    end else if (free_w) begin
      full_d = 1'b0;
      x_tk_d = 1'b0;
      y_tk_d = 1'b0;
    end else begin
      if (sel_i == RD_X) x_tk_d = 1'b1;
      if (sel_i == RD_Y) y_tk_d = 1'b1;
    end
    lost_d = drop_w | (lost_q & ~lost_clr_i);
  end

  assign flag_en = cap_w | free_w | (sel_i != RD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      x_tk_q <= 1'b0;
      y_tk_q <= 1'b0;
    end else if (flag_en) begin
      full_q <= full_d;
      x_tk_q <= x_tk_d;
      y_tk_q <= y_tk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  always_ff @(posedge clk) begin
    if (cap_w) begin
      x_q <= eng_x_i;
      y_q <= eng_y_i;
    end
  end

  assign full_o = full_q;
  assign free_o = free_w;
  assign lost_o = lost_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
endmodule

// File: rtl/mathres_slot.sv
module mathres_slot
  import mrs_pkg::*;
#(
  parameter int W            = 32,
  parameter int CNT_W        = 4,
  parameter bit RELEASE_ON_Y = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_issue_i,
  input  logic         eng_valid_i,
  input  logic [W-1:0] eng_x_i,
  input  logic [W-1:0] eng_y_i,
  input  logic         rd_x_req_i,
  input  logic         rd_y_req_i,
  output logic         rd_x_stall_o,
  output logic         rd_y_stall_o,
  output logic         rd_err_o,
  output logic [W-1:0] rd_data_o,
  output logic         lost_o,
  input  logic         lost_clr_i
);
  rd_sel_e      rd_sel;
  logic         slot_full, slot_free, pend_nz;
  logic [W-1:0] slot_x, slot_y;

  mrs_pending #(.CNT_W(CNT_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (cmd_issue_i),
    .dec_i (eng_valid_i),
    .nz_o  (pend_nz)
  );

  mrs_reader u_rd (
    .rd_x_req_i (rd_x_req_i),
    .rd_y_req_i (rd_y_req_i),
    .full_i     (slot_full),
    .pend_nz_i  (pend_nz),
    .sel_o      (rd_sel),
    .x_stall_o  (rd_x_stall_o),
    .y_stall_o  (rd_y_stall_o),
    .err_o      (rd_err_o)
  );

  mrs_slot #(.W(W), .RELEASE_ON_Y(RELEASE_ON_Y)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_valid_i (eng_valid_i),
    .eng_x_i     (eng_x_i),
    .eng_y_i     (eng_y_i),
    .sel_i       (rd_sel),
    .lost_clr_i  (lost_clr_i),
    .full_o      (slot_full),
    .free_o      (slot_free),
    .lost_o      (lost_o),
    .x_o         (slot_x),
    .y_o         (slot_y)
  );

  always_comb begin
    unique case (rd_sel)
      RD_X:    rd_data_o = slot_x;
      RD_Y:    rd_data_o = slot_y;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/mathres_slot_chk.sv
module mathres_slot_chk (
  input logic clk,
  input logic rst_n,
  input logic eng_valid_i,
  input logic rd_x_req_i,
  input logic rd_y_req_i,
  input logic rd_x_stall_o,
  input logic rd_y_stall_o,
  input logic rd_err_o,
  input logic lost_o,
  input logic lost_clr_i,
  input logic slot_full,
  input logic slot_free,
  input logic pend_nz
);
  assert_capture_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid_i && !slot_full) |=> slot_full);

  assert_stall_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x_stall_o && !rd_err_o) |-> (pend_nz && !slot_full));

  assert_stall_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x_stall_o && eng_valid_i && rd_x_req_i) |=> (rd_x_req_i -> !rd_x_stall_o));

  assert_drop_sets_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid_i && slot_full && !rd_x_req_i && !rd_y_req_i) |=> lost_o);

  assert_lost_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_clr_i && !eng_valid_i) |=> !lost_o);

  assert_no_err_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |-> !rd_err_o);

  assert_free_capture_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && eng_valid_i) |=> slot_full);

  assert_x_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x_req_i && rd_y_req_i) |-> rd_y_stall_o);

  assert_lost_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !lost_clr_i) |=> lost_o);

  always_comb begin
    if (rst_n) begin
      assert_single_outcome_R4: assert ($onehot0({rd_x_stall_o, rd_err_o}));
    end
  end
endmodule

bind mathres_slot mathres_slot_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_valid_i  (eng_valid_i),
  .rd_x_req_i   (rd_x_req_i),
  .rd_y_req_i   (rd_y_req_i),
  .rd_x_stall_o (rd_x_stall_o),
  .rd_y_stall_o (rd_y_stall_o),
  .rd_err_o     (rd_err_o),
  .lost_o       (lost_o),
  .lost_clr_i   (lost_clr_i),
  .slot_full    (slot_full),
  .slot_free    (slot_free),
  .pend_nz      (pend_nz)
);

// File: tb/mathres_slot_tb.sv
module mathres_slot_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_issue_i = 1'b0, eng_valid_i = 1'b0;
  logic [W-1:0] eng_x_i = '0, eng_y_i = '0;
  logic         rd_x_req_i = 1'b0, rd_y_req_i = 1'b0, lost_clr_i = 1'b0;
  logic         rd_x_stall_o, rd_y_stall_o, rd_err_o, lost_o;
  logic [W-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mathres_slot u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_issue_i(cmd_issue_i), .eng_valid_i(eng_valid_i),
    .eng_x_i(eng_x_i), .eng_y_i(eng_y_i), .rd_x_req_i(rd_x_req_i), .rd_y_req_i(rd_y_req_i),
    .rd_x_stall_o(rd_x_stall_o), .rd_y_stall_o(rd_y_stall_o), .rd_err_o(rd_err_o),
    .rd_data_o(rd_data_o), .lost_o(lost_o), .lost_clr_i(lost_clr_i)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_full, m_tx, m_ty, m_lost, n_full, n_tx, n_ty, n_lost;
  logic [W-1:0] m_x, m_y, n_x, n_y;
  int m_pend, n_pend;

  always @(negedge clk) begin
    if (rst_n) begin
      bit ex_stall, ey_stall, eerr, gx, gy, fr;
      logic [W-1:0] edata;
      ex_stall = 0; ey_stall = 0; eerr = 0; gx = 0; gy = 0; edata = '0;
      if (rd_x_req_i) begin
        ey_stall = rd_y_req_i;
        if (m_full) begin gx = 1; edata = m_x; end
        else if (m_pend > 0) ex_stall = 1;
        else eerr = 1;
      end else if (rd_y_req_i) begin
        if (m_full) begin gy = 1; edata = m_y; end
        else if (m_pend > 0) ey_stall = 1;
        else eerr = 1;
      end
      chk("R4", "x_stall", rd_x_stall_o, ex_stall);
      chk("R2", "y_stall", rd_y_stall_o, ey_stall);
      chk("R9", "err", rd_err_o, eerr);
      chk("R5", "data", rd_data_o, edata);
      chk("R7", "lost", lost_o, m_lost);
      fr = m_full && (gx || m_tx) && (gy || m_ty);
      n_full = m_full; n_tx = m_tx; n_ty = m_ty; n_x = m_x; n_y = m_y;
      if (eng_valid_i && (!m_full || fr)) begin
        n_full = 1; n_tx = 0; n_ty = 0; n_x = eng_x_i; n_y = eng_y_i;
      end else if (fr) begin
        n_full = 0; n_tx = 0; n_ty = 0;
      end else begin
        if (gx) n_tx = 1;
        if (gy) n_ty = 1;
      end
      n_lost = (eng_valid_i && m_full && !fr) || (m_lost && !lost_clr_i);
      n_pend = m_pend;
      if (cmd_issue_i && !eng_valid_i && m_pend < 15) n_pend = m_pend + 1;
      if (!cmd_issue_i && eng_valid_i && m_pend > 0) n_pend = m_pend - 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_tx = 0; m_ty = 0; m_lost = 0; m_pend = 0; m_x = '0; m_y = '0;
      n_full = 0; n_tx = 0; n_ty = 0; n_lost = 0; n_pend = 0; n_x = '0; n_y = '0;
    end else begin
      m_full = n_full; m_tx = n_tx; m_ty = n_ty; m_lost = n_lost;
      m_pend = n_pend; m_x = n_x; m_y = n_y;
    end
  end

  task automatic step();
    @(posedge clk); #2;
    cmd_issue_i = 0; eng_valid_i = 0; rd_x_req_i = 0; rd_y_req_i = 0; lost_clr_i = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R12", "lost after reset", lost_o, 0);
    chk("R12", "stall after reset", rd_x_stall_o, 0);
    step(); rd_x_req_i = 1;
    @(negedge clk);
    chk("R9", "err empty nothing pending", rd_err_o, 1);
    chk("R12", "no stall with zero pending", rd_x_stall_o, 0);
    step(); cmd_issue_i = 1;
    step(); rd_x_req_i = 1;
    @(negedge clk); chk("R11", "stall with one pending", rd_x_stall_o, 1);
    step(); rd_x_req_i = 1; eng_valid_i = 1; eng_x_i = 32'h11; eng_y_i = 32'h22;
    @(negedge clk); chk("R6", "still stalled in arrival cycle", rd_x_stall_o, 1);
    step(); rd_x_req_i = 1;
    @(negedge clk);
    chk("R6", "released after arrival", rd_x_stall_o, 0);
    chk("R1", "captured X", rd_data_o, 32'h11);
    step(); rd_y_req_i = 1;
    @(negedge clk); chk("R5", "Y word", rd_data_o, 32'h22);
    step(); rd_x_req_i = 1;
    @(negedge clk); chk("R3", "freed after X and Y", rd_err_o, 1);
    step(); cmd_issue_i = 1;
    step(); cmd_issue_i = 1;
    step(); eng_valid_i = 1; eng_x_i = 32'h33; eng_y_i = 32'h44;
    step(); eng_valid_i = 1; eng_x_i = 32'h55; eng_y_i = 32'h66;
    step(); rd_x_req_i = 1;
    @(negedge clk);
    chk("R7", "lost set", lost_o, 1);
    chk("R7", "held pair kept", rd_data_o, 32'h33);
    step(); lost_clr_i = 1;
    step();
    @(negedge clk); chk("R8", "lost cleared", lost_o, 0);
    step(); cmd_issue_i = 1;
    step(); rd_y_req_i = 1; eng_valid_i = 1; eng_x_i = 32'h77; eng_y_i = 32'h88;
    @(negedge clk); chk("R10", "old Y in freeing cycle", rd_data_o, 32'h44);
    step(); rd_x_req_i = 1;
    @(negedge clk);
    chk("R10", "new X accepted", rd_data_o, 32'h77);
    chk("R10", "no loss", lost_o, 0);
    step(); rd_x_req_i = 1; rd_y_req_i = 1;
    @(negedge clk);
    chk("R2", "X priority", rd_data_o, 32'h77);
    chk("R2", "Y stalls", rd_y_stall_o, 1);
    for (int i = 0; i < 4000; i++) begin
      step();
      cmd_issue_i = ($urandom_range(0, 3) == 0);
      eng_valid_i = (m_pend > 0) ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 30) == 0);
      eng_x_i = $urandom; eng_y_i = $urandom;
      rd_x_req_i = ($urandom_range(0, 2) == 0);
      rd_y_req_i = ($urandom_range(0, 2) == 0);
      lost_clr_i = ($urandom_range(0, 15) == 0);
    end
    step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule